// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block is the timing core of a 160x144 dot-matrix LCD controller. On every dot-clock enable it advances a per-mode dot counter and walks the display through four phases. Each visible line runs through object search, then pixel transfer, then horizontal blank. After the last visible line the display spends ten whole lines in vertical blank before the frame starts again. It keeps the current line number and shows the current phase as a 2-bit code.

Neighbouring logic uses the phase code to decide when video and object memory may be accessed. A one-cycle draw strobe tells the renderer that a line is finished. Two one-cycle interrupt-request pulses are ORed into the system interrupt-flag register: one for the LCD-status source and one for the vertical-blank source. The processor sets which phase entries raise the LCD-status request by writing a status byte. Any processor write to the line register sends the line counter back to zero.

Top module: `lcd_scan_seq`

## Requirements
- R1: After reset, `mode` reads 2 (object search), `line` reads 0, and `draw_line`, `irq_stat` and `irq_vblank` are low.
- R2: The phase encoding on `mode` is horizontal blank = 0, vertical blank = 1, object search = 2, pixel transfer = 3. Object search lasts 80 enabled dots and is then followed by pixel transfer.
- R3: Pixel transfer lasts 172 enabled dots and is then followed by horizontal blank.
- R4: Horizontal blank lasts 204 enabled dots. In the cycle after its last dot, `line` has gone up by one and `draw_line` is high for exactly one cycle. The next phase is object search if the new line is below 144, and vertical blank otherwise.
- R5: Vertical blank is made of lines of 456 enabled dots, and `line` goes up by one after each of them. After the line numbered 153, `line` returns to 0 and the phase becomes object search.
- R6: In a cycle where `dot_en` is low, `mode` and `line` keep their values, and no strobe or interrupt pulse is raised.
- R7: On entry to object search, `irq_stat` pulses for one cycle if status enable bit 5 is set.
- R8: On entry to horizontal blank, `irq_stat` pulses for one cycle if status enable bit 3 is set.
- R9: On entry to vertical blank, `irq_vblank` always pulses for one cycle, and `irq_stat` pulses as well if status enable bit 4 is set.
- R10: A cycle with `line_wr` high makes `line` read 0 in the next cycle. This takes priority over any increment in the same cycle. The phase and the dot position are not changed by it.
- R11: `stat_wr` loads bits 3, 4 and 5 of `stat_wdata` as the enables. The new values apply from the following cycle, the other bits have no effect, and all enables are clear after reset.
- R12: Each interrupt pulse appears in the first cycle that `mode` shows the newly entered phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | One-cycle enable per LCD dot |
| stat_wr | input | 1 | Status enable write strobe |
| stat_wdata | input | 8 | Status write data; bits 3, 4, 5 are the enables |
| line_wr | input | 1 | Line register write strobe; clears the line |
| mode | output | 2 | Current phase code |
| line | output | 8 | Current line number 0..153 |
| draw_line | output | 1 | One-cycle pulse when a visible line is finished |
| irq_stat | output | 1 | One-cycle LCD-status interrupt request |
| irq_vblank | output | 1 | One-cycle vertical-blank interrupt request |

## Verification
A full frame and its wrap are run with a dot enable that is high on about 93 percent of cycles. This separates dots from clock cycles, so a duration counted in clocks instead of enabled dots becomes a phase-length mismatch. Random status writes with noise in the unused bits change the enable set while phases are entered, which shows whether each entry is gated by its own bit and whether the write lands one cycle later. A directed stretch with the dot enable held low tests the freeze. Line writes placed both at random dots and exactly on the last dot of horizontal blank show that clearing wins over the increment without moving the phase.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    MODE_HBL  = 2'd0,
    MODE_VBL  = 2'd1,
    MODE_OAM  = 2'd2,
    MODE_XFER = 2'd3
  } lcd_mode_e;

  // status byte bit positions of the interrupt enables
  localparam int STAT_HBL_BIT = 3;
  localparam int STAT_VBL_BIT = 4;
  localparam int STAT_OAM_BIT = 5;

  typedef struct packed {
    logic oam;
    logic vbl;
    logic hbl;
  } stat_en_t;

  typedef struct packed {
    logic enter_oam;
    logic enter_hbl;
    logic enter_vbl;
    logic hbl_end;
    logic line_step;
    logic frame_wrap;
  } seq_ev_t;

  // number of enabled dots a phase occupies
  function automatic int phase_dots(lcd_mode_e m, int oam_d, int xfer_d,
                                    int hbl_d, int line_d);
    case (m)
      MODE_OAM:  return oam_d;
      MODE_XFER: return xfer_d;
      MODE_HBL:  return hbl_d;
      default:   return line_d;
    endcase
  endfunction

  // phase that follows the last dot of phase m
  function automatic lcd_mode_e phase_after(lcd_mode_e m, logic last_vis,
                                            logic last_frame);
    case (m)
      MODE_OAM:  return MODE_XFER;
      MODE_XFER: return MODE_HBL;
      MODE_HBL:  return last_vis ? MODE_VBL : MODE_OAM;
      default:   return last_frame ? MODE_OAM : MODE_VBL;
    endcase
  endfunction

  // LCD-status request for an entry event under a given enable set
  function automatic logic stat_request(stat_en_t en, logic e_oam,
                                        logic e_hbl, logic e_vbl);
    return (e_oam & en.oam) | (e_hbl & en.hbl) | (e_vbl & en.vbl);
  endfunction

endpackage

// File: rtl/lcd_dot_timer.sv
`timescale 1ns/1ps
module lcd_dot_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dot_en,
  input  logic [CNT_W-1:0] limit,
  output logic             last_dot
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q == limit - CNT_W'(1));
  assign last_dot = dot_en & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (dot_en) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  dot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);

endmodule

// File: rtl/lcd_mode_fsm.sv
`timescale 1ns/1ps
module lcd_mode_fsm
  import lcd_seq_pkg::*;
#(
  parameter int LINE_W      = 8,
  parameter int VIS_LINES   = 144,
  parameter int TOTAL_LINES = 154
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              last_dot,
  input  logic [LINE_W-1:0] line,
  output lcd_mode_e         mode,
  output seq_ev_t           ev
);

  lcd_mode_e mode_q, mode_d;
  logic      last_vis, last_frame;

  assign last_vis   = (line >= LINE_W'(VIS_LINES - 1));
  assign last_frame = (line == LINE_W'(TOTAL_LINES - 1));

  always_comb begin
    mode_d = mode_q;
    if (last_dot) mode_d = phase_after(mode_q, last_vis, last_frame);
  end

  always_comb begin
    ev            = '0;
    ev.enter_oam  = (mode_d == MODE_OAM) && (mode_q != MODE_OAM);
    ev.enter_hbl  = (mode_d == MODE_HBL) && (mode_q != MODE_HBL);
    ev.enter_vbl  = (mode_d == MODE_VBL) && (mode_q != MODE_VBL);
    ev.hbl_end    = last_dot && (mode_q == MODE_HBL);
    ev.frame_wrap = last_dot && (mode_q == MODE_VBL) && last_frame;
    ev.line_step  = ev.hbl_end ||
                    (last_dot && (mode_q == MODE_VBL) && !last_frame);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OAM;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R6
  freeze_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable(mode_q));

  // R2
  oam_to_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OAM && last_dot) |=> mode_q == MODE_XFER);

  // R3
  xfer_to_hbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_XFER && last_dot) |=> mode_q == MODE_HBL);

endmodule

// File: rtl/lcd_line_ctr.sv
`timescale 1ns/1ps
module lcd_line_ctr #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              wrap,
  input  logic              draw_req,
  output logic [LINE_W-1:0] line,
  output logic              draw
);

  logic [LINE_W-1:0] line_q;
  logic              draw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      draw_q <= 1'b0;
    end else begin
      draw_q <= draw_req;
      if (clr || wrap) line_q <= '0;
      else if (step)   line_q <= line_q + LINE_W'(1);
    end
  end

  assign line = line_q;
  assign draw = draw_q;

endmodule

// File: rtl/lcd_irq_gen.sv
`timescale 1ns/1ps
module lcd_irq_gen
  import lcd_seq_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              enter_oam,
  input  logic              enter_hbl,
  input  logic              enter_vbl,
  output logic              irq_stat,
  output logic              irq_vblank
);

  stat_en_t en_q;
  logic     stat_q, vbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= 1'b0;
      vbl_q  <= 1'b0;
    end else begin
      stat_q <= stat_request(en_q, enter_oam, enter_hbl, enter_vbl);
      vbl_q  <= enter_vbl;
      if (stat_wr) begin
        en_q.oam <= stat_wdata[STAT_OAM_BIT];
        en_q.vbl <= stat_wdata[STAT_VBL_BIT];
        en_q.hbl <= stat_wdata[STAT_HBL_BIT];
      end
    end
  end

  assign irq_stat   = stat_q;
  assign irq_vblank = vbl_q;

  // R12
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_oam, enter_hbl, enter_vbl}));

endmodule

// File: rtl/lcd_scan_seq.sv
`timescale 1ns/1ps
module lcd_scan_seq
  import lcd_seq_pkg::*;
#(
  parameter int OAM_DOTS  = 80,
  parameter int XFER_DOTS = 172,
  parameter int HBL_DOTS  = 204,
  parameter int VIS_LINES = 144,
  parameter int VBL_LINES = 10,
  parameter int LINE_W    = 8,
  parameter int STAT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              line_wr,
  output logic [1:0]        mode,
  output logic [LINE_W-1:0] line,
  output logic              draw_line,
  output logic              irq_stat,
  output logic              irq_vblank
);

  localparam int LINE_DOTS   = OAM_DOTS + XFER_DOTS + HBL_DOTS;
  localparam int TOTAL_LINES = VIS_LINES + VBL_LINES;
  localparam int CNT_W       = $clog2(LINE_DOTS + 1);

  lcd_mode_e        cur_mode;
  seq_ev_t          ev;
  logic [CNT_W-1:0] limit;
  logic             last_dot;
  logic [LINE_W-1:0] line_w;

  assign limit = CNT_W'(phase_dots(cur_mode, OAM_DOTS, XFER_DOTS,
                                   HBL_DOTS, LINE_DOTS));

  lcd_dot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .dot_en   (dot_en),
    .limit    (limit),
    .last_dot (last_dot)
  );

  lcd_mode_fsm #(
    .LINE_W      (LINE_W),
    .VIS_LINES   (VIS_LINES),
    .TOTAL_LINES (TOTAL_LINES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dot_en   (dot_en),
    .last_dot (last_dot),
    .line     (line_w),
    .mode     (cur_mode),
    .ev       (ev)
  );

  lcd_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (line_wr),
    .step     (ev.line_step),
    .wrap     (ev.frame_wrap),
    .draw_req (ev.hbl_end),
    .line     (line_w),
    .draw     (draw_line)
  );

  lcd_irq_gen #(.STAT_W(STAT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .enter_oam  (ev.enter_oam),
    .enter_hbl  (ev.enter_hbl),
    .enter_vbl  (ev.enter_vbl),
    .irq_stat   (irq_stat),
    .irq_vblank (irq_vblank)
  );

  assign mode = cur_mode;
  assign line = line_w;

  // R4
  draw_after_hbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draw_line |-> ($past(mode) == MODE_HBL) && (mode != MODE_HBL));

  // R9
  vblank_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vblank |-> (mode == MODE_VBL) && ($past(mode) != MODE_VBL));

  // R12
  stat_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat |-> (mode != $past(mode)));

  // R10
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr |=> line == '0);

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_VBL && mode == MODE_OAM) |-> line == '0);

  // R6
  freeze_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dot_en && !line_wr) |=> $stable(line) && !draw_line && !irq_vblank);

endmodule

// File: tb/sim_lcd_scan_seq.sv
`timescale 1ns/1ps
module sim_lcd_scan_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dot_en, stat_wr, line_wr;
  logic [7:0] stat_wdata;
  logic [1:0] mode;
  logic [7:0] line;
  logic       draw_line, irq_stat, irq_vblank;

  always #2.5 clk = ~clk;

  lcd_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .line_wr(line_wr), .mode(mode), .line(line),
    .draw_line(draw_line), .irq_stat(irq_stat), .irq_vblank(irq_vblank)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference model: position within the line, line, blank flag, enables
  int m_pos = 0, m_line = 0;
  bit m_vb = 0, en3 = 0, en4 = 0, en5 = 0;
  int e_mode = 2;
  bit e_draw = 0, e_istat = 0, e_ivbl = 0;

  function automatic int phase_of(int pos, bit vb);
    if (vb) return 1;
    if (pos < 80) return 2;
    if (pos < 252) return 3;
    return 0;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      2: return "R2";
      3: return "R3";
      0: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit dot, bit swr, logic [7:0] sd, bit lwr);
    int old_m, new_m, nl;
    old_m  = phase_of(m_pos, m_vb);
    nl     = m_line;
    e_draw = 0;
    if (dot) begin
      if (m_pos == 455) begin
        m_pos = 0;
        if (!m_vb) begin
          nl = m_line + 1;
          e_draw = 1;
          if (nl >= 144) m_vb = 1;
        end else if (m_line == 153) begin
          nl = 0;
          m_vb = 0;
        end else begin
          nl = m_line + 1;
        end
      end else begin
        m_pos++;
      end
    end
    m_line  = lwr ? 0 : nl;
    new_m   = phase_of(m_pos, m_vb);
    e_mode  = new_m;
    e_ivbl  = (new_m != old_m) && (new_m == 1);
    e_istat = (new_m != old_m) &&
              ((new_m == 2 && en5) || (new_m == 0 && en3) || (new_m == 1 && en4));
    if (swr) begin
      en3 = sd[3];
      en4 = sd[4];
      en5 = sd[5];
    end
  endtask

  task automatic compare_all();
    chk(mode_tag(e_mode), "mode", int'(mode), e_mode);
    chk("R4/R5/R10", "line", int'(line), m_line);
    chk("R4", "draw_line", int'(draw_line), int'(e_draw));
    chk("R7/R8/R9/R11/R12", "irq_stat", int'(irq_stat), int'(e_istat));
    chk("R9/R12", "irq_vblank", int'(irq_vblank), int'(e_ivbl));
  endtask

  // inputs change at the falling edge; results are sampled one period later
  task automatic drive(bit dot, bit swr, logic [7:0] sd, bit lwr);
    dot_en = dot; stat_wr = swr; stat_wdata = sd; line_wr = lwr;
    model_step(dot, swr, sd, lwr);
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R6 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] hold_m;
    logic [7:0] hold_l;
    void'($urandom(32'd4242));
    rst_n = 1'b0; dot_en = 0; stat_wr = 0; stat_wdata = '0; line_wr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "mode", int'(mode), 2);
    chk("R1", "line", int'(line), 0);
    chk("R1", "pulses", int'({draw_line, irq_stat, irq_vblank}), 0);

    // R11: noise in unused bits only, enables stay clear
    drive(1, 1, 8'hC7, 0);
    for (int i = 0; i < 120; i++) drive(1, 0, 8'h00, 0);
    // R11: all three enables on
    drive(1, 1, 8'h38, 0);
    for (int i = 0; i < 100; i++) drive(1, 0, 8'h00, 0);

    // R6: freeze with the enable held low
    hold_m = mode;
    hold_l = line;
    for (int i = 0; i < 40; i++) begin
      drive(0, 0, 8'h00, 0);
      chk("R6", "frozen mode", int'(mode), int'(hold_m));
      chk("R6", "frozen line", int'(line), int'(hold_l));
    end

    // random run covering a whole frame and its wrap
    for (int i = 0; i < 78000; i++) begin
      bit dot, swr;
      dot = ($urandom % 100) < 93;
      swr = ($urandom % 600) == 0;
      drive(dot, swr, 8'($urandom), 0);
    end

    // R10: line writes at random dots and on the last horizontal-blank dot
    for (int i = 0; i < 20000; i++) begin
      bit lwr;
      lwr = ((m_pos == 455) && !m_vb && (($urandom % 4) == 0)) ||
            (($urandom % 3000) == 0);
      drive(1, 0, 8'h00, lwr);
      if (lwr) chk("R10", "line after write", int'(line), 0);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule